// File: doc/BRIEF.md
# RTC BCD alarm match unit

This block keeps the alarm settings of a real-time clock and turns them into a single sticky alarm flag. It has six byte-wide alarm registers, one each for seconds, minutes, hours, day of week, day of month and month. Each byte holds a two-digit BCD value and its own enable bit. Software reaches the registers over a small synchronous read/write bus.

The timekeeping chain feeds in its BCD counter values and a once-per-second update strobe. On each strobe the block compares every enabled alarm field with its counter. When all enabled fields agree at once, it sets the alarm flag. The flag stays set until software clears it or a manual reset arrives, and a clear never discards a match that lands in the same cycle.

The enable bits come from the asynchronous power-on reset. The digit bits have no reset at all, so a programmed alarm time survives every reset.

Top module: `rtc_alarm`

## Requirements
- R1: Register layout and access. Address 0 holds seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month and 5 month. Bit 7 of each byte is the enable, bits 6..4 the BCD tens digit and bits 3..0 the BCD units digit. A write with `wr_en_i` high stores the byte at the next clock edge. `rd_data_o` shows the stored byte of `addr_i` in the same cycle, and addresses 6 and 7 read as 0x00.
- R2: Asserting `rst_ni` low clears every enable bit to 0. The digit bits 6..0 keep the value they held before the reset.
- R3: When `tick_i` is high at a clock edge and every enabled field's bits 6..0 equal the matching 7-bit counter slice, `alarm_o` is 1 after that edge. Field k's counter slice is `cnt_i[7k+6:7k]`.
- R4: A field whose enable bit is 0 takes no part in the match. A mismatch in that field does not stop the flag from setting.
- R5: When no enable bit is set, `alarm_o` never goes from 0 to 1.
- R6: `alarm_o` can only go from 0 to 1 at an edge where `tick_i` is high. A set flag stays at 1 while neither `clr_i` nor manual reset is applied.
- R7: `clr_i` high at an edge with no new match clears `alarm_o` to 0 after that edge.
- R8: A match on a strobe edge sets `alarm_o` even when `clr_i` or manual reset is also applied in that cycle.
- R9: Synchronous manual reset (`man_rst_ni` low) clears `alarm_o` and leaves all enable and digit bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| man_rst_ni | input | 1 | Synchronous manual reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` |
| cnt_i | input | 42 | BCD counter values, 7 bits per field, field 0 in the low bits |
| tick_i | input | 1 | Counter update strobe |
| clr_i | input | 1 | Alarm flag clear |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
The bench builds the block with its default of six fields and a 3-bit address. This leaves two spare addresses whose zero read-back can be checked. The bench keeps the counters and alarm digits within a few small BCD values, so that random strobes often produce full and partial matches across several enabled fields. Those matches are combined with clears, manual resets and writes in the same cycle, which reaches the priority corners. A mid-run power-on reset shows that the enables drop while the digits survive.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned DIG_W = 7;

  typedef struct packed {
    logic       en;
    logic [2:0] tens;
    logic [3:0] ones;
  } alarm_reg_t;
endpackage

// File: rtl/rtc_alarm_reg.sv
module rtc_alarm_reg
  import rtc_alarm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  alarm_reg_t wdata_i,
  output alarm_reg_t q_o
);
  logic             en_q;
  logic [DIG_W-1:0] dig_q;

  // enable is the only bit with a reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= 1'b0;
    else if (wr_i) en_q <= wdata_i.en;
  end

  // digits survive every reset
  always_ff @(posedge clk_i) begin
    if (wr_i && rst_ni) dig_q <= {wdata_i.tens, wdata_i.ones};
  end

  assign q_o = '{en: en_q, tens: dig_q[6:4], ones: dig_q[3:0]};

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o.en)); // R1
  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> q_o.en == $past(wdata_i.en)); // R1
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 6
) (
  input  logic [NUM_FIELDS-1:0]       en_i,
  input  logic [NUM_FIELDS*DIG_W-1:0] dig_i,
  input  logic [NUM_FIELDS*DIG_W-1:0] cnt_i,
  output logic                        hit_o,
  output logic                        any_en_o
);
  logic [NUM_FIELDS-1:0] ok;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_fld
    // disabled field always passes
    assign ok[k] = !en_i[k] || (dig_i[k*DIG_W +: DIG_W] == cnt_i[k*DIG_W +: DIG_W]);
  end

  assign any_en_o = |en_i;
  assign hit_o    = any_en_o && (&ok);
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic man_rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic any_en_i,
  input  logic clr_i,
  output logic alarm_o
);
  logic alarm_q;
  logic set;

  assign set = tick_i && hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    alarm_q <= 1'b0;
    else if (set)                   alarm_q <= 1'b1;
    else if (clr_i || !man_rst_ni)  alarm_q <= 1'b0;
  end

  assign alarm_o = alarm_q;

  AST_SET_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_q) |-> $past(tick_i)); // R6
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_q && !clr_i && man_rst_ni |=> alarm_q); // R6
  AST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || !man_rst_ni) && !(tick_i && hit_i) |=> !alarm_q); // R7
  AST_MATCH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && hit_i |=> alarm_q); // R8
  AST_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_en_i && !alarm_q |=> !alarm_q); // R5
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 6,
  parameter int unsigned ADDR_W     = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        man_rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        wr_en_i,
  input  logic [REG_W-1:0]            wr_data_i,
  output logic [REG_W-1:0]            rd_data_o,
  input  logic [NUM_FIELDS*DIG_W-1:0] cnt_i,
  input  logic                        tick_i,
  input  logic                        clr_i,
  output logic                        alarm_o
);
  localparam int unsigned CMP_W = NUM_FIELDS * DIG_W;

  alarm_reg_t            regs [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] en;
  logic [CMP_W-1:0]      dig;
  logic                  hit;
  logic                  any_en;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_reg
    rtc_alarm_reg u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && (addr_i == ADDR_W'(k))),
      .wdata_i (alarm_reg_t'(wr_data_i)),
      .q_o     (regs[k])
    );
    assign en[k]                 = regs[k].en;
    assign dig[k*DIG_W +: DIG_W] = {regs[k].tens, regs[k].ones};
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_FIELDS; k++) begin
      if (addr_i == ADDR_W'(k)) rd_data_o = regs[k];
    end
  end

  rtc_alarm_cmp #(.NUM_FIELDS(NUM_FIELDS)) u_cmp (
    .en_i     (en),
    .dig_i    (dig),
    .cnt_i    (cnt_i),
    .hit_o    (hit),
    .any_en_o (any_en)
  );

  rtc_alarm_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .man_rst_ni (man_rst_ni),
    .tick_i     (tick_i),
    .hit_i      (hit),
    .any_en_i   (any_en),
    .clr_i      (clr_i),
    .alarm_o    (alarm_o)
  );

  initial begin
    AST_ADDR_FITS: assert (NUM_FIELDS <= (1 << ADDR_W)); // R1
  end

  AST_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) >= NUM_FIELDS) |-> rd_data_o == '0); // R1
  AST_MAN_KEEPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !man_rst_ni && !wr_en_i |=> $stable(en)); // R9
endmodule

// File: tb/rtc_alarm_test.sv
module rtc_alarm_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 6;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          man_rst_n = 1;
  logic [2:0]    addr = 0;
  logic          wr_en = 0;
  logic [7:0]    wdata = 0;
  logic [7:0]    rdata;
  logic [NF*7-1:0] cnt = '0;
  logic          tick = 0;
  logic          clr = 0;
  logic          alarm;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  logic [7:0] m_reg [NF];
  bit         m_known [NF];
  bit         m_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm uut (
    .clk_i(clk), .rst_ni(rst_n), .man_rst_ni(man_rst_n),
    .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata), .rd_data_o(rdata),
    .cnt_i(cnt), .tick_i(tick), .clr_i(clr), .alarm_o(alarm)
  );

  function automatic bit model_hit();
    bit any = 0;
    bit all = 1;
    for (int k = 0; k < NF; k++) begin
      if (m_reg[k][7]) begin
        any = 1;
        if (m_reg[k][6:0] != cnt[k*7 +: 7]) all = 0;
      end
    end
    return any && all;
  endfunction

  initial for (int k = 0; k < NF; k++) begin m_reg[k] = 8'h00; m_known[k] = 0; end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NF; k++) m_reg[k][7] = 1'b0;
      m_flag = 0;
    end else begin
      if (tick && model_hit()) m_flag = 1;
      else if (clr || !man_rst_n) m_flag = 0;
      if (wr_en && addr < NF) begin
        m_reg[addr] = wdata;
        m_known[addr] = 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always begin
    @(negedge clk);
    #1;
    if (rst_n && !done) begin
      check(alarm === m_flag, "R3 flag vs model", {7'b0, alarm}, {7'b0, m_flag});
      if (addr >= NF)
        check(rdata === 8'h00, "R1 spare read", rdata, 8'h00);
      else if (m_known[addr])
        check(rdata === m_reg[addr], "R1 read vs model", rdata, m_reg[addr]);
      else
        check(rdata[7] === m_reg[addr][7], "R2 enable vs model", rdata, m_reg[addr]);
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); addr = 3'(a); wr_en = 1; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_tick(input bit with_clr);
    @(negedge clk); tick = 1; clr = with_clr;
    @(negedge clk); tick = 0; clr = 0;
  endtask

  task automatic set_cnt(input int k, input logic [6:0] v);
    cnt[k*7 +: 7] = v;
  endtask

  task automatic expect_flag(input string tag, input bit exp);
    #2;
    check(alarm === exp, tag, {7'b0, alarm}, {7'b0, exp});
  endtask

  task automatic expect_rd(input int a, input string tag, input logic [7:0] exp);
    addr = 3'(a);
    #2;
    check(rdata === exp, tag, rdata, exp);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD*3);
    @(negedge clk); rst_n = 1;
    #2;
    for (int k = 0; k < NF; k++) begin
      addr = 3'(k); #1;
      check(rdata[7] === 1'b0, "R2 enable after power-on", rdata, 8'h00);
    end
    check(alarm === 1'b0, "R6 flag after power-on", {7'b0, alarm}, 8'h00);

    // program digits, all disabled
    wr(0, 8'h45); wr(1, 8'h30); wr(2, 8'h12); wr(3, 8'h03); wr(4, 8'h21); wr(5, 8'h07);
    expect_rd(0, "R1 seconds read", 8'h45);
    expect_rd(5, "R1 month read", 8'h07);
    expect_rd(6, "R1 spare address", 8'h00);
    expect_rd(7, "R1 spare address", 8'h00);

    // counters equal to all digits; none enabled
    set_cnt(0, 7'h45); set_cnt(1, 7'h30); set_cnt(2, 7'h12);
    set_cnt(3, 7'h03); set_cnt(4, 7'h21); set_cnt(5, 7'h07);
    pulse_tick(0);
    expect_flag("R5 no enables", 0);

    // seconds enabled, match, no tick
    wr(0, 8'hC5);
    repeat (3) @(negedge clk);
    expect_flag("R6 no tick no set", 0);
    pulse_tick(0);
    expect_flag("R3 single field match", 1);
    repeat (2) @(negedge clk);
    expect_flag("R6 sticky", 1);
    do_clear();
    expect_flag("R7 clear", 0);

    // seconds and minutes, minutes mismatch
    wr(1, 8'hB0);
    set_cnt(1, 7'h31);
    pulse_tick(0);
    expect_flag("R3 partial mismatch", 0);
    set_cnt(1, 7'h30);
    // hours disabled and mismatched
    set_cnt(2, 7'h23);
    pulse_tick(0);
    expect_flag("R4 disabled field ignored", 1);

    // clear and match in same cycle
    pulse_tick(1);
    expect_flag("R8 match wins over clear", 1);
    do_clear();
    expect_flag("R7 clear", 0);

    // manual reset
    pulse_tick(0);
    @(negedge clk); man_rst_n = 0;
    @(negedge clk); man_rst_n = 1;
    expect_flag("R9 manual reset clears", 0);
    expect_rd(0, "R9 manual reset keeps register", 8'hC5);
    expect_rd(1, "R9 manual reset keeps register", 8'hB0);

    // manual reset with match in the same cycle
    @(negedge clk); man_rst_n = 0; tick = 1;
    @(negedge clk); man_rst_n = 1; tick = 0;
    expect_flag("R8 match wins over manual reset", 1);

    // all six enabled
    for (int k = 0; k < NF; k++) wr(k, m_reg[k] | 8'h80);
    set_cnt(2, 7'h12);
    do_clear();
    pulse_tick(0);
    expect_flag("R3 all fields match", 1);
    do_clear();
    set_cnt(5, 7'h08);
    pulse_tick(0);
    expect_flag("R3 month mismatch", 0);

    // power-on reset in mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    expect_rd(0, "R2 digits kept, enable cleared", 8'h45);
    expect_rd(4, "R2 digits kept, enable cleared", 8'h21);
    expect_flag("R2 flag after reset", 0);
    pulse_tick(0);
    expect_flag("R5 enables cleared by reset", 0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      tick = ($urandom_range(0, 2) == 0);
      clr = ($urandom_range(0, 7) == 0);
      man_rst_n = ($urandom_range(0, 19) != 0);
      addr = 3'($urandom_range(0, 7));
      wr_en = ($urandom_range(0, 3) == 0);
      wdata = {1'($urandom_range(0, 1)), 3'($urandom_range(0, 1)), 4'($urandom_range(0, 1))};
      if ($urandom_range(0, 3) == 0) begin
        int k = $urandom_range(0, NF - 1);
        set_cnt(k, {3'($urandom_range(0, 1)), 4'($urandom_range(0, 1))});
      end
    end
    @(negedge clk);
    tick = 0; clr = 0; man_rst_n = 1; wr_en = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    bad++;
    total++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule